// File: doc/BRIEF.md
# Logic Analyzer Trigger and Capture

This block watches every device pin of a vector tester on every tester clock and keeps a running record of the samples in a circular memory. Once armed, it looks for a trigger condition. The condition is either the n-th injection of a stimulus vector since arming, or a pattern of levels and edges on a masked set of pins. When the trigger fires, the block keeps a selectable share of history before the trigger sample. It then stores enough further samples to fill the buffer, stops writing and raises a done flag.

After capture, the stored window is read through an address and data port. The address is relative to the oldest valid sample, so the reader never deals with the physical write position. If the trigger arrives before enough history exists, it is still accepted. The window is then shorter, and its length is reported on a port. Pulsing the arm input restarts the whole process from any state.

Top module: `la_capture`

## Requirements
- R1: After reset, `trig` and `done` are low and `cap_len` is zero.
- R2: With `cfg_mode` = 0 (vector count), the trigger fires in the cycle where `vec_strobe` is high for the n-th time since arming, n = `cfg_count`. A value of n = 0 never fires. Pin configuration has no effect in this mode.
- R3: With `cfg_mode` = 1 (pin pattern), the trigger fires in the first cycle where every pin with its `cfg_mask` bit set meets its condition. For a pin with its `cfg_edge_en` bit clear, the condition is that the pin equals its `cfg_value` bit. Pins with a clear mask bit are ignored.
- R4: For a masked pin with its `cfg_edge_en` bit set, the condition is a transition: the pin differs from the previous sample and now equals its `cfg_value` bit (1 = rising, 0 = falling). The first sample after arming has no previous sample, so it never counts as an edge.
- R5: In pin mode, an all-zero `cfg_mask` never fires the trigger.
- R6: `cfg_pos` sets the pre-trigger sample count P, latched at arm: 0 gives floor(DEPTH*20/100), 1 and 3 give DEPTH/2, and 2 gives floor(DEPTH*80/100). With at least P earlier samples, readout index P holds the trigger sample.
- R7: The trigger sample and the samples after it total exactly DEPTH-P. `done` rises at the clock edge that writes the last of them, no later sample is written, and `done` implies `trig`.
- R8: If fewer than P samples precede the trigger, `cap_len` equals that count plus DEPTH-P, and readout index 0 is the first sample after arming. In all cases `cap_len` is min(history, P) + DEPTH-P.
- R9: `rd_data` shows, one clock after `rd_addr` is applied, the sample at that offset from the oldest stored sample.
- R10: `trig` goes high at the edge of the trigger cycle and holds. A pulse on `arm` clears `trig`, `done`, `cap_len` and the vector count, and starts a new capture on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tester clock; one sample per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a new capture (clears previous state) |
| pins | input | NPINS | Current pin sample |
| vec_strobe | input | 1 | A stimulus vector is injected this cycle |
| cfg_mode | input | 1 | 0 = vector count trigger, 1 = pin pattern trigger |
| cfg_count | input | CNT_W | Vector ordinal n that fires the count trigger |
| cfg_mask | input | NPINS | Pins taking part in the pin trigger |
| cfg_value | input | NPINS | Required level, or level after the edge |
| cfg_edge_en | input | NPINS | 1 = pin condition is a transition |
| cfg_pos | input | 2 | Pre-trigger share select |
| rd_addr | input | log2(DEPTH) | Readout offset from oldest sample |
| trig | output | 1 | Trigger has fired since arming |
| done | output | 1 | Capture complete |
| cap_len | output | log2(DEPTH)+1 | Number of valid samples in the window |
| rd_data | output | NPINS | Sample at `rd_addr`, one cycle later |

## Verification
The trigger decision and the sample write act on the same sample in the same cycle. So the trigger sample must land as the first post-trigger entry, and not one slot early or late. The bench provokes this in two ways. It sets a condition that matches in the very first armed cycle, and it lets a trigger fire long after the buffer has wrapped. It judges the result by reading back the whole window against a record of every driven sample. The trigger sample must sit at index min(history, P), and `cap_len` must match.

// File: rtl/la_pkg.sv
package la_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } la_state_e;

  // pre-trigger sample count for a position select (R6)
  function automatic int unsigned pre_len(input logic [1:0] pos, input int unsigned depth);
    case (pos)
      2'd0:    return (depth * 20) / 100;
      2'd2:    return (depth * 80) / 100;
      default: return depth / 2;
    endcase
  endfunction

endpackage

// File: rtl/la_trig_eval.sv
module la_trig_eval #(
  parameter int NPINS = 96,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             sample_en,
  input  logic [NPINS-1:0] pins,
  input  logic             vec_strobe,
  input  logic             cfg_mode,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [NPINS-1:0] cfg_mask,
  input  logic [NPINS-1:0] cfg_value,
  input  logic [NPINS-1:0] cfg_edge_en,
  output logic             hit
);

  logic [NPINS-1:0] prev_pins;
  logic             prev_valid;
  logic [CNT_W-1:0] vec_cnt;
  logic [NPINS-1:0] pin_ok;
  logic             count_hit;
  logic             pin_hit;

  always_ff @(posedge clk) begin
    if (!rst_n || arm) begin
      prev_pins  <= '0;
      prev_valid <= 1'b0;
      vec_cnt    <= '0;
    end else if (sample_en) begin
      prev_pins  <= pins;
      prev_valid <= 1'b1;
      if (vec_strobe && vec_cnt != '1) vec_cnt <= vec_cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_comb begin
      if (!cfg_mask[i])        pin_ok[i] = 1'b1;
      else if (cfg_edge_en[i]) pin_ok[i] = prev_valid && (prev_pins[i] != pins[i])
                                           && (pins[i] == cfg_value[i]);
      else                     pin_ok[i] = (pins[i] == cfg_value[i]);
    end
  end

  assign count_hit = vec_strobe && (cfg_count != '0) && (vec_cnt + 1'b1 == cfg_count);
  assign pin_hit   = (&pin_ok) && (|cfg_mask);
  assign hit       = cfg_mode ? pin_hit : count_hit;

  assert_count_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && hit) |-> vec_strobe);
  assert_edge_needs_history_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && hit && |(cfg_mask & cfg_edge_en)) |-> prev_valid);
  assert_empty_mask_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && cfg_mask == '0) |-> !hit);

endmodule

// File: rtl/la_sample_ram.sv
module la_sample_ram #(
  parameter int WIDTH = 96,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
  import la_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [1:0]    cfg_pos,
  input  logic          hit,
  output logic          wr_en,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] start_ptr,
  output logic [LW-1:0] cap_len,
  output logic          trig_seen,
  output logic          done
);

  la_state_e     state;
  logic [LW-1:0] fill;
  logic [LW-1:0] pre_q;
  logic [LW-1:0] post_left;
  logic [LW-1:0] post_len;
  logic [LW-1:0] hist_len;
  logic          trig_fire;

  assign post_len  = LW'(DEPTH) - pre_q;
  assign hist_len  = (fill < pre_q) ? fill : pre_q;
  assign wr_en     = (state == ST_PRE) || (state == ST_POST);
  assign trig_fire = (state == ST_PRE) && hit;
  assign done      = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wr_ptr    <= '0;
      start_ptr <= '0;
      fill      <= '0;
      pre_q     <= '0;
      post_left <= '0;
      cap_len   <= '0;
      trig_seen <= 1'b0;
    end else if (arm) begin
      state     <= ST_PRE;
      wr_ptr    <= '0;
      start_ptr <= '0;
      fill      <= '0;
      pre_q     <= LW'(pre_len(cfg_pos, DEPTH));
      post_left <= '0;
      cap_len   <= '0;
      trig_seen <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      case (state)
        ST_PRE: begin
          if (trig_fire) begin
            trig_seen <= 1'b1;
            start_ptr <= wr_ptr - hist_len[AW-1:0];
            cap_len   <= hist_len + post_len;
            if (post_len <= LW'(1)) begin
              state <= ST_DONE;
            end else begin
              state     <= ST_POST;
              post_left <= post_len - 1'b1;
            end
          end else if (fill != LW'(DEPTH)) begin
            fill <= fill + 1'b1;
          end
        end
        ST_POST: begin
          post_left <= post_left - 1'b1;
          if (post_left == LW'(1)) state <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  assert_done_implies_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> trig_seen);
  assert_frozen_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> ($stable(wr_ptr) && done));
  assert_len_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_seen |-> (cap_len <= LW'(DEPTH) && cap_len >= post_len));
  assert_single_fire_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |-> !trig_seen);
  assert_trig_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_seen && !arm) |=> trig_seen);
  assert_arm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!trig_seen && !done && cap_len == '0));

endmodule

// File: rtl/la_capture.sv
module la_capture #(
  parameter int NPINS = 96,
  parameter int DEPTH = 1024,
  parameter int CNT_W = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [NPINS-1:0] pins,
  input  logic             vec_strobe,
  input  logic             cfg_mode,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [NPINS-1:0] cfg_mask,
  input  logic [NPINS-1:0] cfg_value,
  input  logic [NPINS-1:0] cfg_edge_en,
  input  logic [1:0]       cfg_pos,
  input  logic [AW-1:0]    rd_addr,
  output logic             trig,
  output logic             done,
  output logic [LW-1:0]    cap_len,
  output logic [NPINS-1:0] rd_data
);

  logic          hit;
  logic          wr_en;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] start_ptr;
  logic [AW-1:0] rd_phys;

  la_trig_eval #(.NPINS(NPINS), .CNT_W(CNT_W)) i_eval (
    .clk, .rst_n, .arm,
    .sample_en (wr_en),
    .pins, .vec_strobe, .cfg_mode, .cfg_count,
    .cfg_mask, .cfg_value, .cfg_edge_en,
    .hit
  );

  la_capture_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk, .rst_n, .arm, .cfg_pos, .hit,
    .wr_en, .wr_ptr, .start_ptr, .cap_len,
    .trig_seen (trig),
    .done
  );

  // offset from the oldest sample, wrapping around the power-of-two buffer
  assign rd_phys = start_ptr + rd_addr;

  la_sample_ram #(.WIDTH(NPINS), .DEPTH(DEPTH)) i_ram (
    .clk,
    .we    (wr_en),
    .waddr (wr_ptr),
    .wdata (pins),
    .raddr (rd_phys),
    .rdata (rd_data)
  );

endmodule

// File: tb/test_la_capture.sv
module test_la_capture;

  localparam int NP    = 96;
  localparam int DEPTH = 64;
  localparam int CW    = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = AW + 1;
  localparam int P20   = (DEPTH * 2) / 10;
  localparam int P50   = DEPTH >> 1;
  localparam int P80   = (DEPTH * 8) / 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          vec_strobe = 1'b0;
  logic          cfg_mode = 1'b0;
  logic [CW-1:0] cfg_count = '0;
  logic [NP-1:0] cfg_mask = '0;
  logic [NP-1:0] cfg_value = '0;
  logic [NP-1:0] cfg_edge_en = '0;
  logic [1:0]    cfg_pos = 2'd0;
  logic [AW-1:0] rd_addr = '0;
  logic          trig;
  logic          done;
  logic [LW-1:0] cap_len;
  logic [NP-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  int k      = 0;
  logic [NP-1:0] hist [0:511];

  la_capture #(.NPINS(NP), .DEPTH(DEPTH), .CNT_W(CW)) i_la_capture (
    .clk, .rst_n, .arm, .pins, .vec_strobe, .cfg_mode, .cfg_count,
    .cfg_mask, .cfg_value, .cfg_edge_en, .cfg_pos, .rd_addr,
    .trig, .done, .cap_len, .rd_data
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] pat(input int sc, input int n);
    logic [NP-1:0] p;
    p = {32'(n) ^ 32'h5A5A_0F0F, ~32'(n), 32'(n)};
    if (sc == 2) begin
      p[5]  = 1'b1;
      p[90] = (n < 3) || (n >= 10);
    end
    return p;
  endfunction

  function automatic logic strb(input int sc, input int n);
    return (sc == 0) ? n[0] : 1'b1;
  endfunction

  task automatic step(input logic [NP-1:0] p, input logic s);
    pins = p;
    vec_strobe = s;
    hist[k] = p;
    @(posedge clk);
    @(negedge clk);
    k++;
  endtask

  task automatic arm_it(input string req);
    arm = 1'b1;
    @(posedge clk);
    @(negedge clk);
    arm = 1'b0;
    k = 0;
    chk(trig == 1'b0, {req, " R10 arm clears trig"}, NP'(trig), '0);
    chk(done == 1'b0, {req, " R10 arm clears done"}, NP'(done), '0);
    chk(cap_len == '0, {req, " R10 arm clears cap_len"}, NP'(cap_len), '0);
  endtask

  // run one capture with a known trigger cycle kt and pre-trigger count pre
  task automatic run_case(input int sc, input int kt, input int pre, input string req);
    int post, last, h, len;
    post = DEPTH - pre;
    last = kt + post - 1;
    h    = (kt < pre) ? kt : pre;
    len  = h + post;
    arm_it(req);
    for (int n = 0; n <= last + 4; n++) begin
      step(pat(sc, n), strb(sc, n));
      if (n == kt - 1) chk(trig == 1'b0, {req, " R10 trig low before trigger"}, NP'(trig), '0);
      if (n == kt)     chk(trig == 1'b1, {req, " R10 trig high after trigger"}, NP'(trig), 1);
      if (n == last - 1) chk(done == 1'b0, {req, " R7 done not early"}, NP'(done), '0);
      if (n == last)     chk(done == 1'b1, {req, " R7 done on last post sample"}, NP'(done), 1);
    end
    chk(cap_len == LW'(len), {req, " R8 cap_len"}, NP'(cap_len), NP'(len));
    for (int i = 0; i < len; i++) begin
      rd_addr = AW'(i);
      @(posedge clk);
      @(negedge clk);
      chk(rd_data == hist[kt - h + i], {req, " R9 readout"}, rd_data, hist[kt - h + i]);
    end
    rd_addr = AW'(h);
    @(posedge clk);
    @(negedge clk);
    chk(rd_data == hist[kt], {req, " R6 trigger sample index"}, rd_data, hist[kt]);
  endtask

  task automatic t_reset;
    chk(trig == 1'b0, "R1 trig after reset", NP'(trig), '0);
    chk(done == 1'b0, "R1 done after reset", NP'(done), '0);
    chk(cap_len == '0, "R1 cap_len after reset", NP'(cap_len), '0);
  endtask

  task automatic t_count_trigger;
    cfg_mode = 1'b0; cfg_count = CW'(50); cfg_pos = 2'd1;
    cfg_mask = '1; cfg_value = '0; cfg_edge_en = '0;
    // strobes on odd cycles: the 50th is at cycle 99
    run_case(0, 99, P50, "R2");
  endtask

  task automatic t_value_trigger;
    cfg_mode = 1'b1; cfg_pos = 2'd0;
    cfg_mask = NP'(8'hFF); cfg_value = {{(NP-8){1'b1}}, 8'd40}; cfg_edge_en = '0;
    run_case(1, 40, P20, "R3");
  endtask

  task automatic t_edge_trigger;
    cfg_mode = 1'b1; cfg_pos = 2'd2;
    cfg_mask = '0; cfg_mask[90] = 1'b1; cfg_mask[5] = 1'b1;
    cfg_value = '0; cfg_value[90] = 1'b1; cfg_value[5] = 1'b1;
    cfg_edge_en = '0; cfg_edge_en[90] = 1'b1;
    // pin 90 high from arm (no edge), falls at 3, rises at 10; early trigger
    run_case(2, 10, P80, "R4");
  endtask

  task automatic t_first_cycle;
    cfg_mode = 1'b1; cfg_pos = 2'd0;
    cfg_mask = NP'(1); cfg_value = '0; cfg_edge_en = '0;
    run_case(3, 0, P20, "R8");
  endtask

  task automatic t_never(input bit mode, input string req);
    cfg_mode = mode; cfg_count = '0; cfg_mask = '0; cfg_value = '0;
    cfg_edge_en = '0; cfg_pos = 2'd1;
    arm_it(req);
    for (int n = 0; n < 150; n++) step(pat(4, n), 1'b1);
    chk(trig == 1'b0, {req, " no trigger"}, NP'(trig), '0);
    chk(done == 1'b0, {req, " no done"}, NP'(done), '0);
    chk(cap_len == '0, {req, " no window"}, NP'(cap_len), '0);
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count_trigger();
    t_value_trigger();
    t_edge_trigger();
    t_first_cycle();
    t_never(1'b1, "R5");
    t_never(1'b0, "R2 n=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule